// File: doc/BRIEF.md
# Cascaded Masked Interrupt Controller

This block collects 96 interrupt sources into one prioritised request for a processor. Sources 0 to 31 arrive as level inputs in a low main group, and sources 32 to 63 arrive as level inputs in a high main group. Sources 64 to 95 are general-purpose pins. A rising edge on a pin sets a sticky bit in a pin cause register. Four summary bits in the high group report the state of that pin register, one bit for each block of eight pins. Each of the three groups has its own mask register.

Every cycle the block picks the winning source and registers it. The low group is searched first. Within a group the highest-numbered pending, unmasked bit wins. When the high-group winner is a summary bit, the pin group is searched under the pin mask. The result is a 7-bit source number with a valid flag, plus a combined request line.

Software uses a plain register port to set the masks, read the causes and the vector, and acknowledge pins. A pin is acknowledged by writing zeros to its bits in the pin cause register. The vector is a status output that is refreshed every cycle, not a stream. It carries no ready signal and so has no back-pressure: a consumer samples it whenever it needs it.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: The vector number is the bit index for a low-group winner, 32 plus the bit index for a non-summary high-group winner, and 64 plus the pin bit index for a pin winner.
- R2: Only low cause bits in pattern 0x3dfffffe and high cause bits in pattern 0x0f000db7 can raise a request. Low bits 0, 25, 30, 31 and high bits 3, 6, 9, 12 to 23 and 28 to 31 have no effect on `vec_valid`, `vec_num` or `irq_req`.
- R3: Any pending, unmasked, valid low-group bit wins over every high-group and pin source.
- R4: Within a group, the highest-numbered bit that is both pending and unmasked wins.
- R5: High cause bit 24+k (k=0..3) reads as the OR of pin cause bits 8k to 8k+7, ignoring the pin mask. The `hi_src` inputs 24 to 27 are not used. When a summary bit wins the high search, the pin group is searched with its own mask.
- R6: If a summary bit wins but no unmasked pin cause bit is set, `vec_valid` is 0 while `irq_req` is 1.
- R7: A write to the pin cause register (offset 0x10) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R8: After reset all three masks read 0, the pin cause reads 0, and `vec_valid` and `irq_req` are 0.
- R9: A pin cause bit is set by a 0-to-1 change of its input, not by a held level. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: `vec_valid`, `vec_num` and `irq_req` are registered and follow the cause and mask state one clock later. `irq_req` is 1 when any valid main-group bit (summary bits included) is pending and unmasked.
- R11: The register offsets are: low cause 0x00, high cause 0x04, low mask 0x08, high mask 0x0C, pin cause 0x10, pin mask 0x14, vector 0x18. The vector reads as bit 7 = valid and bits 6:0 = number. Writes to the cause registers at 0x00 and 0x04, and to the vector at 0x18, are ignored. Unmapped offsets read 0.
- R12: A write to a mask offset stores the write data, which reads back unchanged and gates the matching group from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_src | input | 32 | Level inputs for sources 0-31 |
| hi_src | input | 32 | Level inputs for sources 32-63 (bits 24-27 unused) |
| pin_in | input | 32 | Pin inputs for sources 64-95, edge captured |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| vec_valid | output | 1 | Winning source present |
| vec_num | output | 7 | Winning source number |
| irq_req | output | 1 | Combined interrupt request |

## Verification
A wrong mask bit or a wrong pin cause bit appears on `vec_num` or `irq_req` one clock after the state settles. It also appears at once on a register read at the matching offset. A pin bit that fails to stick, or that clears when it should not, changes the summary read at offset 0x04 and the pin winner in the next cycle. A priority error shows up as a wrong number when several groups are pending together. The bench is built to create that situation, and it checks after every stimulus step.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int GRP_W  = 32;
  localparam int VEC_W  = 7;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_LO_CAUSE  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_HI_CAUSE  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LO_MASK   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_HI_MASK   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_PIN_CAUSE = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_PIN_MASK  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_VECTOR    = 5'h18;

  typedef struct packed {
    logic             valid;
    logic [VEC_W-1:0] num;
  } vec_t;
endpackage

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
  parameter int W     = 32,
  localparam int IW   = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  // R4: the chosen bit is set and nothing above it is set
  always_comb begin
    if (found) begin
      a_r4_highest_wins: assert ((req >> idx) == W'(1));
    end
  end
endmodule

// File: rtl/irq_pin_capture.sv
module irq_pin_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic         clr_we,
  input  logic [W-1:0] clr_keep,
  output logic [W-1:0] cause
);
  logic [W-1:0] pin_q;
  logic [W-1:0] rise;
  logic [W-1:0] keep;

  assign rise = pin_in & ~pin_q;
  assign keep = clr_we ? clr_keep : {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= '0;
      cause <= '0;
    end else begin
      pin_q <= pin_in;
      cause <= (cause & keep) | rise;
    end
  end

  // R9: a captured edge is present in the next cycle, even against a clear
  a_r9_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((cause & $past(rise)) == $past(rise)));

  // R7: with no edge, bits written as zero are clear afterwards
  a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && rise == '0) |=> ((cause & ~$past(clr_keep)) == '0));

  // R9: a held or falling input never sets a bit by itself
  a_r9_no_level_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rise == '0) |=> ((cause & ~$past(cause)) == '0));
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_cascade_pkg::*;
#(
  parameter int W = GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      lo_mask,
  output logic [W-1:0]      hi_mask,
  output logic [W-1:0]      pin_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_mask  <= '0;
      hi_mask  <= '0;
      pin_mask <= '0;
    end else if (wr) begin
      unique case (addr)
        OFS_LO_MASK:  lo_mask  <= wdata;
        OFS_HI_MASK:  hi_mask  <= wdata;
        OFS_PIN_MASK: pin_mask <= wdata;
        default: ;
      endcase
    end
  end

  // R12: a mask write is stored verbatim
  a_r12_lo_mask_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_LO_MASK) |=> (lo_mask == $past(wdata)));
  a_r12_pin_mask_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_PIN_MASK) |=> (pin_mask == $past(wdata)));
  // R11: other offsets leave the high mask alone
  a_r11_hi_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS_HI_MASK) |=> $stable(hi_mask));
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter logic [GRP_W-1:0] LO_VALID   = 32'h3dff_fffe,
  parameter logic [GRP_W-1:0] HI_VALID   = 32'h0f00_0db7,
  parameter int               SUM_LSB    = 24,
  parameter int               PIN_SLICES = 4,
  localparam int              SLICE_W    = GRP_W / PIN_SLICES,
  localparam int              IW         = $clog2(GRP_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_W-1:0]  lo_src,
  input  logic [GRP_W-1:0]  hi_src,
  input  logic [GRP_W-1:0]  pin_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [GRP_W-1:0]  reg_wdata,
  output logic [GRP_W-1:0]  reg_rdata,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_num,
  output logic              irq_req
);
  logic [GRP_W-1:0] lo_mask, hi_mask, pin_mask, pin_cause;
  logic [GRP_W-1:0] hi_cause, lo_eff, hi_eff, pin_eff;
  logic [PIN_SLICES-1:0] summary;
  logic lo_found, hi_found, pin_found;
  logic [IW-1:0] lo_idx, hi_idx, pin_idx;
  vec_t next_vec;

  irq_mask_regs #(.W(GRP_W)) u_masks (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .lo_mask(lo_mask), .hi_mask(hi_mask),
    .pin_mask(pin_mask)
  );

  irq_pin_capture #(.W(GRP_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .clr_we(reg_wr && reg_addr == OFS_PIN_CAUSE),
    .clr_keep(reg_wdata), .cause(pin_cause)
  );

  for (genvar k = 0; k < PIN_SLICES; k++) begin : g_sum
    assign summary[k] = |pin_cause[k*SLICE_W +: SLICE_W];
  end

  always_comb begin
    hi_cause = hi_src;
    hi_cause[SUM_LSB +: PIN_SLICES] = summary;
  end

  assign lo_eff  = lo_src   & LO_VALID & lo_mask;
  assign hi_eff  = hi_cause & HI_VALID & hi_mask;
  assign pin_eff = pin_cause & pin_mask;

  irq_prio_find #(.W(GRP_W)) u_lo  (.req(lo_eff),  .found(lo_found),  .idx(lo_idx));
  irq_prio_find #(.W(GRP_W)) u_hi  (.req(hi_eff),  .found(hi_found),  .idx(hi_idx));
  irq_prio_find #(.W(GRP_W)) u_pin (.req(pin_eff), .found(pin_found), .idx(pin_idx));

  always_comb begin
    next_vec = '0;
    if (lo_found) begin
      next_vec.valid = 1'b1;
      next_vec.num   = VEC_W'(lo_idx);
    end else if (hi_found) begin
      if (int'(hi_idx) >= SUM_LSB) begin
        next_vec.valid = pin_found;
        next_vec.num   = pin_found ? VEC_W'(2 * GRP_W) + VEC_W'(pin_idx) : '0;
      end else begin
        next_vec.valid = 1'b1;
        next_vec.num   = VEC_W'(GRP_W) + VEC_W'(hi_idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_num   <= '0;
      irq_req   <= 1'b0;
    end else begin
      vec_valid <= next_vec.valid;
      vec_num   <= next_vec.num;
      irq_req   <= lo_found || hi_found;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_LO_CAUSE:  reg_rdata = lo_src;
      OFS_HI_CAUSE:  reg_rdata = hi_cause;
      OFS_LO_MASK:   reg_rdata = lo_mask;
      OFS_HI_MASK:   reg_rdata = hi_mask;
      OFS_PIN_CAUSE: reg_rdata = pin_cause;
      OFS_PIN_MASK:  reg_rdata = pin_mask;
      OFS_VECTOR:    reg_rdata = GRP_W'({vec_valid, vec_num});
      default:       reg_rdata = '0;
    endcase
  end

  // R3: a live low-group request yields a low-group number next cycle
  a_r3_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_eff != '0) |=> (vec_valid && vec_num < VEC_W'(GRP_W)));

  // R10: the request line follows the main groups one cycle later
  a_r10_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_eff != '0 || hi_eff != '0) |=> irq_req);
  a_r10_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_eff == '0 && hi_eff == '0) |=> (!irq_req && !vec_valid));

  // R1: pin winners land in the top third of the number space
  a_r1_pin_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_eff == '0 && hi_eff[SUM_LSB-1:0] == '0 && hi_eff != '0 && pin_eff != '0)
    |=> (vec_valid && vec_num >= VEC_W'(2 * GRP_W)));

  // R6: a valid vector is never reported without the request line
  a_r6_valid_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> irq_req);
endmodule

// File: tb/sim_irq_cascade_ctrl.sv
module sim_irq_cascade_ctrl;
  localparam int PERIOD = 10;
  localparam logic [31:0] LOV = 32'h3dff_fffe;
  localparam logic [31:0] HIV = 32'h0f00_0db7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] lo_src = '0, hi_src = '0, pin_in = '0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic vec_valid, irq_req;
  logic [6:0] vec_num;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_lo_mask = '0, m_hi_mask = '0, m_pin_mask = '0;
  logic [31:0] m_pin_cause = '0, m_prev = '0;

  irq_cascade_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .lo_src(lo_src), .hi_src(hi_src),
    .pin_in(pin_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_valid(vec_valid),
    .vec_num(vec_num), .irq_req(irq_req)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int top_bit(input logic [31:0] v);
    int r = -1;
    for (int i = 0; i < 32; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [31:0] m_hi_cause();
    logic [31:0] h = hi_src;
    for (int k = 0; k < 4; k++) h[24+k] = |m_pin_cause[8*k +: 8];
    return h;
  endfunction

  // returns {irq, valid, num}
  function automatic logic [8:0] m_result();
    int l, h, p;
    l = top_bit(lo_src & LOV & m_lo_mask);
    h = top_bit(m_hi_cause() & HIV & m_hi_mask);
    p = top_bit(m_pin_cause & m_pin_mask);
    if (l >= 0) return {1'b1, 1'b1, 7'(l)};
    if (h < 0)  return 9'd0;
    if (h < 24) return {1'b1, 1'b1, 7'(32 + h)};
    if (p < 0)  return {1'b1, 1'b0, 7'd0};
    return {1'b1, 1'b1, 7'(64 + p)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock edge, updating the model exactly as the requirements state
  task automatic tick();
    logic [31:0] rise;
    @(posedge clk);
    rise = pin_in & ~m_prev;
    if (rst_n) begin
      if (reg_wr && reg_addr == 5'h10) m_pin_cause = (m_pin_cause & reg_wdata) | rise; // R7, R9
      else m_pin_cause = m_pin_cause | rise;
      if (reg_wr && reg_addr == 5'h08) m_lo_mask  = reg_wdata;
      if (reg_wr && reg_addr == 5'h0C) m_hi_mask  = reg_wdata;
      if (reg_wr && reg_addr == 5'h14) m_pin_mask = reg_wdata;
    end
    m_prev = rst_n ? pin_in : '0;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  // R10: outputs are compared once state has been stable for a clock
  task automatic settle_check(input string req);
    logic [8:0] e;
    tick(); tick();
    e = m_result();
    check({req, " irq"}, 32'(irq_req), 32'(e[8]));
    check({req, " valid"}, 32'(vec_valid), 32'(e[7]));
    if (e[7]) check({req, " num"}, 32'(vec_num), 32'(e[6:0]));
    rd_check({req, " pincause"}, 5'h10, m_pin_cause);
    rd_check({req, " hicause"}, 5'h04, m_hi_cause());
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 valid", 32'(vec_valid), 0);
    check("R8 irq", 32'(irq_req), 0);
    rd_check("R8 lo mask", 5'h08, 0);
    rd_check("R8 hi mask", 5'h0C, 0);
    rd_check("R8 pin mask", 5'h14, 0);
    rd_check("R8 pin cause", 5'h10, 0);

    // R12 masks store and read back
    wr(5'h08, 32'hffff_ffff);
    rd_check("R12 lo mask", 5'h08, 32'hffff_ffff);
    wr(5'h0C, 32'hffff_ffff);
    wr(5'h14, 32'hffff_ffff);
    rd_check("R12 pin mask", 5'h14, 32'hffff_ffff);

    // R2 invalid bits only: nothing happens
    lo_src = ~LOV; hi_src = ~HIV & 32'hf0ff_ffff;
    settle_check("R2 invalid only");
    check("R2 no valid", 32'(vec_valid), 0);
    check("R2 no irq", 32'(irq_req), 0);

    // R3 low beats high, R4 top low bit wins, R1 numbering
    lo_src = 32'h0000_0012; hi_src = 32'h0000_0400;
    settle_check("R3 low first");
    check("R4 num 4", 32'(vec_num), 4);
    lo_src = 0;
    settle_check("R1 high number");
    check("R1 num 42", 32'(vec_num), 42);

    // R11 writes to read-only cause offsets ignored
    lo_src = 32'h0000_0100;
    wr(5'h00, 32'h0);
    rd_check("R11 lo cause ro", 5'h00, 32'h0000_0100);
    settle_check("R11 after ro write");
    rd_check("R11 vector read", 5'h18, {24'd0, 1'b1, 7'd8});
    rd_check("R11 unmapped", 5'h1C, 0);
    lo_src = 0; hi_src = 0;

    // R5 pin via summary, R1 pin numbering
    pin_in = 32'h0001_0004;
    settle_check("R5 pin edge");
    check("R1 pin num 80", 32'(vec_num), 80);
    // R7 acknowledge one pin with the complement
    wr(5'h10, ~32'h0001_0000);
    settle_check("R7 w0c one bit");
    check("R7 pin num 66", 32'(vec_num), 66);
    // R9 held level does not re-set after clear
    wr(5'h10, 32'h0);
    settle_check("R9 held level");
    check("R9 cleared", m_pin_cause, 0);

    // R9 set beats clear in the same cycle
    pin_in = 0; tick();
    pin_in = 32'h8000_0000; reg_wr = 1'b1; reg_addr = 5'h10; reg_wdata = 32'h0;
    tick();
    settle_check("R9 set wins");
    check("R9 num 95", 32'(vec_num), 95);

    // R6 summary with pin masked: bogus but request raised
    wr(5'h14, 32'h0);
    settle_check("R6 bogus");
    check("R6 valid low", 32'(vec_valid), 0);
    check("R6 irq high", 32'(irq_req), 1);
    wr(5'h14, 32'hffff_ffff);

    // random mix
    for (int it = 0; it < 400; it++) begin
      lo_src = $urandom() & $urandom();
      hi_src = $urandom();
      pin_in = $urandom();
      case ($urandom_range(0, 5))
        0: wr(5'h08, $urandom() & $urandom() & $urandom());
        1: wr(5'h0C, $urandom());
        2: wr(5'h14, $urandom());
        3: wr(5'h10, $urandom());
        default: ;
      endcase
      settle_check("R1 R3 R4 R5 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule